// File: doc/BRIEF.md
# Fallback Static Branch Predictor with Return Stack

This block supplies a direction and a target for a decoded branch when the branch target buffer has nothing to offer for it. A fixed decision tree, keyed on the branch kind, on whether the target is relative to the instruction pointer, and on the sign of the displacement, picks the direction. Returns take their target from a small return-address stack. Call and return events push and pop that stack independently of the decode stream.

A separate resolution port reports branches once their outcome is known. Only branches that resolve as taken produce an allocation request toward the target buffer. The request carries a set index and a slot within the 16-byte fetch block, both taken from the branch address, together with the resolved target. This lets the target buffer predict the branch itself the next time it is met. The prediction and the allocation request are both registered and appear one cycle after their inputs.

Top module: `static_bpred`

## Requirements
- R1: A prediction (`pred_valid`=1 one cycle later) is produced only for a cycle with `dec_valid`=1 and `tb_hit`=0. A target-buffer hit or an idle decode gives `pred_valid`=0.
- R2: For `br_kind`=1 (conditional) with `ip_rel`=1, a backward displacement (`disp_neg`=1) is predicted taken with target `calc_target`. A forward one is predicted not taken with target 0. A conditional branch with `ip_rel`=0 is predicted not taken.
- R3: For `br_kind`=0 (unconditional), the prediction is taken with target `calc_target` and `pred_tgt_ok`=1.
- R4: For `br_kind`=3 (register-indirect), the prediction is taken with target `reg_target` and `pred_tgt_ok`=1.
- R5: For `br_kind`=2 (return), the prediction is taken. Its target is the most recently pushed address not yet popped, and `pred_tgt_ok`=1. The stack read uses the state before that cycle's push or pop.
- R6: A return predicted while the stack is empty gives `pred_tgt_ok`=0 and target 0. A pop of an empty stack leaves it empty.
- R7: The stack holds `RAS_DEPTH` (8) entries. A push into a full stack discards the oldest entry and keeps the newest eight.
- R8: A push and a pop in the same cycle act as pop then push: the top entry is replaced by `call_addr`, and the depth is unchanged. On an empty stack the pair leaves one entry.
- R9: `upd_valid` rises one cycle after `res_valid`=1 with `res_taken`=1, and only then. It carries `upd_index`=`res_ip[10:4]`, `upd_slot`=`res_ip[3:2]` and `upd_target`=`res_target`.
- R10: While `rst` is high, both `pred_valid` and `upd_valid` are 0, and reset leaves the return stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded branch is presented |
| tb_hit | input | 1 | Target buffer already predicted this branch |
| br_kind | input | 2 | 0 unconditional, 1 conditional, 2 return, 3 register-indirect |
| ip_rel | input | 1 | Target is relative to the instruction pointer |
| disp_neg | input | 1 | Displacement points backwards |
| calc_target | input | 32 | Target computed from the displacement |
| reg_target | input | 32 | Resolved register value for indirect jumps |
| call_evt | input | 1 | Push `call_addr` onto the return stack |
| call_addr | input | 32 | Return address of the call |
| ret_evt | input | 1 | Pop the return stack |
| res_valid | input | 1 | A branch outcome is reported |
| res_taken | input | 1 | The reported branch was taken |
| res_ip | input | 32 | Address of the reported branch |
| res_target | input | 32 | Target of the reported branch |
| pred_valid | output | 1 | Static prediction valid |
| pred_taken | output | 1 | Predicted direction |
| pred_tgt_ok | output | 1 | Predicted target is usable |
| pred_target | output | 32 | Predicted target |
| upd_valid | output | 1 | Allocation request to the target buffer |
| upd_index | output | 7 | Target-buffer set index |
| upd_slot | output | 2 | Slot within the fetch block |
| upd_target | output | 32 | Target to allocate |

## Verification
The bench pushes eleven addresses into the eight-deep stack and drains it with return decodes. A design that failed to drop the oldest entry, or that saturated without overwriting, returns the wrong addresses near the bottom or reports the empty case late. Same-cycle call and return pairs are applied to full, partly filled and empty stacks. If the push were ordered before the pop, the top would vanish instead of being replaced. The bench also pops past empty: an underflowing pointer would then hand back stale addresses with a valid flag. Forward and backward conditional branches are mixed with target-buffer hits and not-taken resolutions. This exposes a design that predicts on a hit or allocates a branch that never went taken.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        BK_UNCOND = 2'd0,
        BK_COND   = 2'd1,
        BK_RET    = 2'd2,
        BK_INDIR  = 2'd3
    } br_kind_e;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  taken;
        logic  tgt_ok;
        addr_t target;
    } guess_t;

    // Fixed decision tree for branches the target buffer did not cover.
    function automatic guess_t decide(
        br_kind_e kind,
        logic     ip_rel,
        logic     backward,
        addr_t    rel_tgt,
        addr_t    reg_tgt,
        addr_t    stk_top,
        logic     stk_ok
    );
        guess_t g;
        g = '0;
        unique case (kind)
            BK_UNCOND: begin
                g.taken  = 1'b1;
                g.tgt_ok = 1'b1;
                g.target = rel_tgt;
            end
            BK_COND: begin
                if (ip_rel && backward) begin
                    g.taken  = 1'b1;
                    g.tgt_ok = 1'b1;
                    g.target = rel_tgt;
                end
            end
            BK_RET: begin
                g.taken  = 1'b1;
                g.tgt_ok = stk_ok;
                g.target = stk_ok ? stk_top : '0;
            end
            BK_INDIR: begin
                g.taken  = 1'b1;
                g.tgt_ok = 1'b1;
                g.target = reg_tgt;
            end
        endcase
        return g;
    endfunction

endpackage

// File: rtl/sbp_ret_stack.sv
module sbp_ret_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr,
    output logic          top_ok
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] top_ptr;
    logic [CW-1:0] fill;
    logic          nonempty;
    logic          full;

    assign top_ptr  = wr_ptr - 1'b1;
    assign nonempty = (fill != '0);
    assign full     = (fill == CW'(DEPTH));
    assign top_addr = slots[top_ptr];
    assign top_ok   = nonempty;

    // Pointer and depth: pop is applied before push when both arrive.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            unique case ({push, pop})
                2'b10: begin
                    wr_ptr <= wr_ptr + 1'b1;
                    if (!full) fill <= fill + 1'b1;
                end
                2'b01: begin
                    if (nonempty) begin
                        wr_ptr <= wr_ptr - 1'b1;
                        fill   <= fill - 1'b1;
                    end
                end
                2'b11: begin
                    if (!nonempty) begin
                        wr_ptr <= wr_ptr + 1'b1;
                        fill   <= CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Entry storage, no reset needed: reads are masked by the depth count.
    always_ff @(posedge clk) begin
        if (push) begin
            if (pop && nonempty) slots[top_ptr] <= push_addr;
            else                 slots[wr_ptr]  <= push_addr;
        end
    end

endmodule

// File: rtl/sbp_alloc_req.sv
module sbp_alloc_req #(
    parameter int AW          = 32,
    parameter int TB_ENTRIES  = 512,
    parameter int TB_SLOTS    = 4,
    parameter int FETCH_BYTES = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  res_valid,
    input  logic                                  res_taken,
    input  logic [AW-1:0]                         res_ip,
    input  logic [AW-1:0]                         res_target,
    output logic                                  upd_valid,
    output logic [$clog2(TB_ENTRIES/TB_SLOTS)-1:0] upd_index,
    output logic [$clog2(TB_SLOTS)-1:0]           upd_slot,
    output logic [AW-1:0]                         upd_target
);
    localparam int IDX_W  = $clog2(TB_ENTRIES / TB_SLOTS);
    localparam int SLOT_W = $clog2(TB_SLOTS);
    localparam int BLK_LSB = $clog2(FETCH_BYTES);

    logic seen_taken;
    assign seen_taken = res_valid && res_taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_valid  <= 1'b0;
            upd_index  <= '0;
            upd_slot   <= '0;
            upd_target <= '0;
        end else begin
            upd_valid <= seen_taken;
            if (seen_taken) begin
                upd_index  <= res_ip[BLK_LSB +: IDX_W];
                upd_slot   <= res_ip[BLK_LSB-1 -: SLOT_W];
                upd_target <= res_target;
            end
        end
    end

endmodule

// File: rtl/static_bpred.sv
module static_bpred
    import sbp_pkg::*;
#(
    parameter int RAS_DEPTH   = 8,
    parameter int TB_ENTRIES  = 512,
    parameter int TB_SLOTS    = 4,
    parameter int FETCH_BYTES = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   dec_valid,
    input  logic                                   tb_hit,
    input  logic [1:0]                             br_kind,
    input  logic                                   ip_rel,
    input  logic                                   disp_neg,
    input  logic [ADDR_W-1:0]                      calc_target,
    input  logic [ADDR_W-1:0]                      reg_target,
    input  logic                                   call_evt,
    input  logic [ADDR_W-1:0]                      call_addr,
    input  logic                                   ret_evt,
    input  logic                                   res_valid,
    input  logic                                   res_taken,
    input  logic [ADDR_W-1:0]                      res_ip,
    input  logic [ADDR_W-1:0]                      res_target,
    output logic                                   pred_valid,
    output logic                                   pred_taken,
    output logic                                   pred_tgt_ok,
    output logic [ADDR_W-1:0]                      pred_target,
    output logic                                   upd_valid,
    output logic [$clog2(TB_ENTRIES/TB_SLOTS)-1:0] upd_index,
    output logic [$clog2(TB_SLOTS)-1:0]            upd_slot,
    output logic [ADDR_W-1:0]                      upd_target
);
    addr_t  stk_top;
    logic   stk_ok;
    logic   need_static;
    guess_t guess;
    guess_t guess_q;
    logic   valid_q;

    sbp_ret_stack #(
        .DEPTH (RAS_DEPTH),
        .AW    (ADDR_W)
    ) ras_i (
        .clk       (clk),
        .rst       (rst),
        .push      (call_evt),
        .pop       (ret_evt),
        .push_addr (call_addr),
        .top_addr  (stk_top),
        .top_ok    (stk_ok)
    );

    assign need_static = dec_valid && !tb_hit;
    assign guess = decide(br_kind_e'(br_kind), ip_rel, disp_neg,
                          calc_target, reg_target, stk_top, stk_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            guess_q <= '0;
        end else begin
            valid_q <= need_static;
            guess_q <= need_static ? guess : '0;
        end
    end

    assign pred_valid  = valid_q;
    assign pred_taken  = guess_q.taken;
    assign pred_tgt_ok = guess_q.tgt_ok;
    assign pred_target = guess_q.target;

    sbp_alloc_req #(
        .AW          (ADDR_W),
        .TB_ENTRIES  (TB_ENTRIES),
        .TB_SLOTS    (TB_SLOTS),
        .FETCH_BYTES (FETCH_BYTES)
    ) alloc_i (
        .clk        (clk),
        .rst        (rst),
        .res_valid  (res_valid),
        .res_taken  (res_taken),
        .res_ip     (res_ip),
        .res_target (res_target),
        .upd_valid  (upd_valid),
        .upd_index  (upd_index),
        .upd_slot   (upd_slot),
        .upd_target (upd_target)
    );

endmodule

// File: rtl/sbp_checker.sv
module sbp_checker
    import sbp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dec_valid,
    input logic              tb_hit,
    input logic [1:0]        br_kind,
    input logic              ip_rel,
    input logic              disp_neg,
    input logic [ADDR_W-1:0] reg_target,
    input logic              res_valid,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic              pred_valid,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_target,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_target
);
    AST_QUIET_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && tb_hit) |=> !pred_valid); // R1

    AST_FWD_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !tb_hit && br_kind == 2'd1 && ip_rel && !disp_neg)
        |=> (pred_valid && !pred_taken)); // R2

    AST_INDIR_TARGET: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !tb_hit && br_kind == 2'd3)
        |=> (pred_taken && pred_target == $past(reg_target))); // R4

    AST_ALLOC_ONLY_TAKEN: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> $past(res_valid && res_taken)); // R9

    AST_ALLOC_TARGET: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken) |=> (upd_valid && upd_target == $past(res_target))); // R9

endmodule

bind static_bpred sbp_checker chk_i (.*);

// File: tb/static_bpred_tb_top.sv
module static_bpred_tb_top;
    import sbp_pkg::*;

    localparam int STK_DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 0, tb_hit = 0, ip_rel = 0, disp_neg = 0;
    logic [1:0]  br_kind = 0;
    addr_t       calc_target = 0, reg_target = 0, call_addr = 0, res_ip = 0, res_target = 0;
    logic        call_evt = 0, ret_evt = 0, res_valid = 0, res_taken = 0;
    logic        pred_valid, pred_taken, pred_tgt_ok, upd_valid;
    addr_t       pred_target, upd_target;
    logic [6:0]  upd_index;
    logic [1:0]  upd_slot;

    int    checks = 0;
    int    fails  = 0;
    addr_t stk[$];
    string ret_tag = "R5";

    always #4 clk = ~clk;

    static_bpred dut_i (.*);

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        dec_valid = 0; tb_hit = 0; br_kind = 0; ip_rel = 0; disp_neg = 0;
        calc_target = 0; reg_target = 0; call_evt = 0; ret_evt = 0; call_addr = 0;
        res_valid = 0; res_taken = 0; res_ip = 0; res_target = 0;
    endtask

    // One cycle: model the expected outputs, let the edge pass, compare at negedge.
    task automatic step();
        logic  e_pv, e_pt, e_ok, e_uv;
        addr_t e_tgt;
        string tag;
        e_pv = dec_valid && !tb_hit;
        e_pt = 0; e_ok = 0; e_tgt = 0;
        tag = "R1";
        if (e_pv) begin
            if (br_kind == 2'd0) begin
                tag = "R3"; e_pt = 1; e_ok = 1; e_tgt = calc_target;
            end else if (br_kind == 2'd1) begin
                tag = "R2";
                if (ip_rel && disp_neg) begin e_pt = 1; e_ok = 1; e_tgt = calc_target; end
            end else if (br_kind == 2'd3) begin
                tag = "R4"; e_pt = 1; e_ok = 1; e_tgt = reg_target;
            end else begin
                tag = ret_tag; e_pt = 1;
                if (stk.size() > 0) begin e_ok = 1; e_tgt = stk[stk.size()-1]; end
            end
        end
        e_uv = res_valid && res_taken;
        if (ret_evt && stk.size() > 0) void'(stk.pop_back());
        if (call_evt) begin
            if (stk.size() == STK_DEPTH) void'(stk.pop_front());
            stk.push_back(call_addr);
        end
        begin
            addr_t s_ip, s_tgt;
            s_ip = res_ip; s_tgt = res_target;
            @(negedge clk);
            chk(tag, "pred_valid", 64'(pred_valid), 64'(e_pv));
            if (e_pv) begin
                chk(tag, "pred_taken", 64'(pred_taken), 64'(e_pt));
                chk(tag, "pred_tgt_ok", 64'(pred_tgt_ok), 64'(e_ok));
                chk(tag, "pred_target", 64'(pred_target), 64'(e_tgt));
            end
            chk("R9", "upd_valid", 64'(upd_valid), 64'(e_uv));
            if (e_uv) begin
                chk("R9", "upd_index", 64'(upd_index), 64'(s_ip[10:4]));
                chk("R9", "upd_slot", 64'(upd_slot), 64'(s_ip[3:2]));
                chk("R9", "upd_target", 64'(upd_target), 64'(s_tgt));
            end
        end
        idle();
    endtask

    task automatic decode(logic [1:0] k, logic rel, logic back, addr_t ct, addr_t rt);
        dec_valid = 1; tb_hit = 0; br_kind = k; ip_rel = rel; disp_neg = back;
        calc_target = ct; reg_target = rt;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle();
        rst = 1;
        dec_valid = 1; res_valid = 1; res_taken = 1;
        repeat (3) @(negedge clk);
        chk("R10", "pred_valid in reset", 64'(pred_valid), 64'd0);
        chk("R10", "upd_valid in reset", 64'(upd_valid), 64'd0);
        idle();
        rst = 0;
        // R10: stack empty after reset
        ret_tag = "R10";
        decode(2'd2, 0, 0, 0, 0); step();
        ret_tag = "R5";

        // R1: hits and idle decodes give nothing
        decode(2'd0, 1, 0, 32'h100, 0); tb_hit = 1; step();
        dec_valid = 0; br_kind = 2'd3; step();
        // R2
        decode(2'd1, 1, 1, 32'h0000_0f00, 0); step();
        decode(2'd1, 1, 0, 32'h0000_2000, 0); step();
        decode(2'd1, 0, 1, 32'h0000_3000, 0); step();
        // R3, R4
        decode(2'd0, 1, 0, 32'h0000_4444, 0); step();
        decode(2'd3, 0, 0, 32'h1, 32'hdead_beef); step();

        // R5: push two, read back in reverse
        call_evt = 1; call_addr = 32'ha000; step();
        call_evt = 1; call_addr = 32'hb000; step();
        decode(2'd2, 0, 0, 0, 0); ret_evt = 1; step();
        decode(2'd2, 0, 0, 0, 0); ret_evt = 1; step();
        // R6: underflow
        ret_tag = "R6";
        ret_evt = 1; step();
        decode(2'd2, 0, 0, 0, 0); step();
        ret_tag = "R5";

        // R7: eleven pushes, drain with return decodes
        ret_tag = "R7";
        for (int i = 0; i < 11; i++) begin
            call_evt = 1; call_addr = 32'hc000 + 32'(i * 16); step();
        end
        for (int i = 0; i < 9; i++) begin
            decode(2'd2, 0, 0, 0, 0); ret_evt = 1; step();
        end

        // R8: same-cycle pop then push on partial, empty and full stacks
        ret_tag = "R8";
        call_evt = 1; call_addr = 32'he000; step();
        call_evt = 1; ret_evt = 1; call_addr = 32'he100; step();
        decode(2'd2, 0, 0, 0, 0); ret_evt = 1; step();
        decode(2'd2, 0, 0, 0, 0); call_evt = 1; ret_evt = 1; call_addr = 32'he200; step();
        decode(2'd2, 0, 0, 0, 0); step();
        for (int i = 0; i < 8; i++) begin
            call_evt = 1; call_addr = 32'hf000 + 32'(i); step();
        end
        call_evt = 1; ret_evt = 1; call_addr = 32'hf0ff; step();
        decode(2'd2, 0, 0, 0, 0); ret_evt = 1; step();
        decode(2'd2, 0, 0, 0, 0); ret_evt = 1; step();
        ret_tag = "R5";

        // R9: only taken resolutions allocate
        res_valid = 1; res_taken = 0; res_ip = 32'h1234; res_target = 32'h9; step();
        res_valid = 1; res_taken = 1; res_ip = 32'h0000_07fc; res_target = 32'h8888; step();
        res_valid = 0; res_taken = 1; res_ip = 32'h10; step();
        res_valid = 1; res_taken = 1; res_ip = 32'hffff_fff4; res_target = 32'h77; step();

        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            dec_valid   = $urandom_range(0, 3) != 0;
            tb_hit      = $urandom_range(0, 4) == 0;
            br_kind     = 2'($urandom_range(0, 3));
            ip_rel      = 1'($urandom);
            disp_neg    = 1'($urandom);
            calc_target = $urandom;
            reg_target  = $urandom;
            call_evt    = $urandom_range(0, 2) == 0;
            call_addr   = $urandom;
            ret_evt     = $urandom_range(0, 2) == 0;
            res_valid   = 1'($urandom);
            res_taken   = 1'($urandom);
            res_ip      = $urandom;
            res_target  = $urandom;
            step();
        end
        summary();
    end

endmodule